// File: doc/BRIEF.md
# Tree Mismatch-Shaping Element Selector

This block selects which of eight equal-weight one-bit DAC cells are switched high for each sample of a nine-level converter. Each sample it receives an unsigned level code from 0 to 8 and drives eight cell lines whose number of ones equals that code. The choice of *which* cells are high is made so that every cell's usage error is first-order highpass shaped. The low-frequency content of the mismatch error therefore moves out of the signal band of an oversampled converter.

The selector is a binary tree of seven two-way splitting nodes arranged in three levels. The root receives the count (0 to 8), the two middle nodes receive 0 to 4, and the four leaves receive 0 to 2 and drive two cell lines each. A node that receives an even count splits it equally between its two children. A node that receives an odd count gives the extra unit to one child, and records the choice as a sign: +1 means the upper child got the extra unit.

Signs are issued in pairs. Each node is a three-state machine:
- `PAIR_IDLE`: no pair is open. On an odd count the node opens a pair. Its private pseudo-random bit decides the sign. Bit 0 sends +1 and moves to `OWE_MINUS`. Bit 1 sends -1 and moves to `OWE_PLUS`.
- `OWE_MINUS`: on the next odd count the node sends -1 and returns to `PAIR_IDLE`.
- `OWE_PLUS`: on the next odd count the node sends +1 and returns to `PAIR_IDLE`.

Even counts leave the state unchanged. The random bits come from distinct taps of one 16-bit LFSR. The data path from code to cell lines is combinational; only the node states and the LFSR advance on the clock.

Top module: `dem_tree_enc`

## Requirements
- R1: In every cycle the number of ones on `cell_drive` equals `level_code`, for codes 0 to 8, within the same cycle.
- R2: Codes 9 to 15 are treated as 8, so all eight cell lines are 1.
- R3: A node covering the span of lines given below, whose count is even, has equal numbers of ones in the upper and lower halves of its span. Span rule: the node at depth d and position p (from the top) covers 8>>d lines, starting at bit 7-p*(8>>d) and going down. The upper half is the more significant half.
- R4: A node whose count is odd has halves that differ by exactly one.
- R5: For each node, the running sum of its signs (upper-half ones minus lower-half ones, taken over its odd-count samples) stays within -1..+1. The sample that closes a pair carries the opposite sign of the one that opened it.
- R6: Samples on which a node's count is even leave its open pair untouched, so the next odd sample still closes it with the opposite sign.
- R7: The sign that opens a pair comes from a pseudo-random bit. Over a long run, every node opens pairs of both signs.
- R8: An active-low asynchronous reset returns every node to `PAIR_IDLE`, and the sign sums restart from zero. During reset, code 0 gives all-zero lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| level_code | input | 4 | Unsigned level 0..8 (9..15 saturate to 8) |
| cell_drive | output | 8 | One line per one-bit DAC cell |

## Verification
A node stuck in the wrong pair state shows at the ports on the very next sample whose count for that node is odd: the halves of its span tilt the same way twice, and the running sign sum reaches ±2. A node that alters its state on even counts shows in the same way, on the first odd sample after an even one. A wrong split shows in the same cycle as the stimulus, as a wrong number of ones or unequal halves. A random source that is stuck shows only over many samples, as one pair type never occurring at that node.

// File: rtl/dem_pkg.sv
package dem_pkg;
    typedef enum logic [1:0] {
        PAIR_IDLE = 2'd0,
        OWE_MINUS = 2'd1,
        OWE_PLUS  = 2'd2
    } pair_state_e;
endpackage

// File: rtl/dem_lfsr.sv
module dem_lfsr #(
    parameter int          LFSR_W   = 16,
    parameter logic [15:0] TAPS     = 16'hB400,
    parameter logic [15:0] SEED     = 16'hACE1,
    parameter int          NUM_BITS = 7,
    parameter int          TAP_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_BITS-1:0] rnd_bits
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS[LFSR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED[LFSR_W-1:0];
        end else begin
            state_q <= state_d;
        end
    end

    // each consumer gets its own tap position
    for (genvar b = 0; b < NUM_BITS; b++) begin : g_tap
        localparam int TAP_IDX = (b * TAP_STEP) % LFSR_W;
        assign rnd_bits[b] = state_q[TAP_IDX];
    end
endmodule

// File: rtl/dem_split_node.sv
module dem_split_node
    import dem_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_in,
    input  logic          rnd,
    output logic [CW-1:0] up_cnt,
    output logic [CW-1:0] lo_cnt
);
    pair_state_e state_q;
    pair_state_e state_d;
    logic        odd;
    logic        give_up;
    logic [CW-1:0] half;

    assign odd  = cnt_in[0];
    assign half = cnt_in >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        give_up = 1'b0;
        unique case (state_q)
            PAIR_IDLE: begin
                give_up = ~rnd;
                if (odd) begin
                    state_d = rnd ? OWE_PLUS : OWE_MINUS;
                end
            end
            OWE_MINUS: begin
                give_up = 1'b0;
                if (odd) begin
                    state_d = PAIR_IDLE;
                end
            end
            OWE_PLUS: begin
                give_up = 1'b1;
                if (odd) begin
                    state_d = PAIR_IDLE;
                end
            end
            default: begin
                state_d = PAIR_IDLE;
            end
        endcase
    end

    assign up_cnt = half + {{(CW-1){1'b0}}, odd & give_up};
    assign lo_cnt = half + {{(CW-1){1'b0}}, odd & ~give_up};
endmodule

// File: rtl/dem_tree_enc.sv
module dem_tree_enc #(
    parameter int          LEVELS   = 3,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter int          TAP_STEP = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LEVELS:0]          level_code,
    output logic [(1<<LEVELS)-1:0]   cell_drive
);
    localparam int OUT_W  = 1 << LEVELS;
    localparam int CODE_W = LEVELS + 1;
    localparam int NODES  = OUT_W - 1;
    localparam int SLOTS  = 2 * OUT_W - 1;

    logic [CODE_W-1:0] cnt [SLOTS];
    logic [NODES-1:0]  rnd_bits;

    assign cnt[0] = (level_code > CODE_W'(OUT_W)) ? CODE_W'(OUT_W) : level_code;

    dem_lfsr #(
        .LFSR_W  (16),
        .TAPS    (16'hB400),
        .SEED    (LFSR_SEED),
        .NUM_BITS(NODES),
        .TAP_STEP(TAP_STEP)
    ) rng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rnd_bits(rnd_bits)
    );

    for (genvar j = 0; j < NODES; j++) begin : g_node
        dem_split_node #(.CW(CODE_W)) node_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_in(cnt[j]),
            .rnd   (rnd_bits[j]),
            .up_cnt(cnt[2*j+1]),
            .lo_cnt(cnt[2*j+2])
        );
    end

    for (genvar m = 0; m < OUT_W; m++) begin : g_leaf
        assign cell_drive[OUT_W-1-m] = (cnt[NODES+m] != '0);
    end
endmodule

// File: rtl/dem_tree_enc_chk.sv
module dem_tree_enc_chk #(
    parameter int LEVELS = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LEVELS:0]        level_code,
    input logic [(1<<LEVELS)-1:0] cell_drive
);
    localparam int OUT_W = 1 << LEVELS;
    localparam int HALF  = OUT_W / 2;

    int   sat_code;
    int   root_up;
    int   root_lo;
    logic code_odd;
    logic open_q;
    logic plus_q;

    assign sat_code = (int'(level_code) > OUT_W) ? OUT_W : int'(level_code);
    assign root_up  = $countones(cell_drive[OUT_W-1:HALF]);
    assign root_lo  = $countones(cell_drive[HALF-1:0]);
    assign code_odd = sat_code[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            plus_q <= 1'b0;
        end else if (code_odd) begin
            open_q <= ~open_q;
            plus_q <= (root_up > root_lo);
        end
    end

    // R1
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cell_drive) == sat_code);

    // R2
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level_code) > OUT_W) |-> (&cell_drive));

    // R3
    even_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_odd |-> (root_up == root_lo));

    // R4
    odd_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_odd |-> ((root_up == root_lo + 1) || (root_lo == root_up + 1)));

    // R5
    pair_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_odd && open_q) |-> (plus_q ? (root_up < root_lo) : (root_up > root_lo)));
endmodule

bind dem_tree_enc dem_tree_enc_chk #(.LEVELS(LEVELS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_code(level_code),
    .cell_drive(cell_drive)
);

// File: tb/dem_tree_enc_tb_top.sv
module dem_tree_enc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] level_code = 4'd0;
    logic [7:0] cell_drive;

    int vec_cnt = 0;
    int bad_cnt = 0;
    int run_sum [7];
    bit gap_seen [7];
    int open_pos [7];
    int open_neg [7];
    bit done = 1'b0;

    dem_tree_enc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_code(level_code),
        .cell_drive(cell_drive)
    );

    always #2.5ns clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%0d expected=%0d (code=%0d)", req, act, exp, level_code);
        end
    endtask

    function automatic int pop_rng(input logic [7:0] v, input int hi, input int lo);
        int n = 0;
        for (int b = lo; b <= hi; b++) n += int'(v[b]);
        return n;
    endfunction

    task automatic clear_model();
        for (int j = 0; j < 7; j++) begin
            run_sum[j]  = 0;
            gap_seen[j] = 1'b0;
        end
    endtask

    task automatic apply(input int code);
        int exp_n;
        @(negedge clk);
        level_code = code[3:0];
        #1ns;
        exp_n = (code > 8) ? 8 : code;
        chk($countones(cell_drive) == exp_n, "R1", $countones(cell_drive), exp_n);
        if (code > 8) chk(cell_drive == 8'hFF, "R2", int'(cell_drive), 255);
        for (int j = 0; j < 7; j++) begin
            int d, p, span, top, u, l, k, s;
            d = 0;
            while (((1 << (d + 1)) - 1) <= j) d++;
            p    = j + 1 - (1 << d);
            span = 8 >> d;
            top  = 7 - p * span;
            u = pop_rng(cell_drive, top, top - span/2 + 1);
            l = pop_rng(cell_drive, top - span/2, top - span + 1);
            k = u + l;
            s = u - l;
            if ((k % 2) == 0) begin
                chk(s == 0, "R3", s, 0);
                if (run_sum[j] != 0) gap_seen[j] = 1'b1;
            end else begin
                chk((s == 1) || (s == -1), "R4", s, 1);
                if (run_sum[j] == 0) begin
                    if (s > 0) open_pos[j]++; else open_neg[j]++;
                    run_sum[j] = (s > 0) ? 1 : -1;
                end else begin
                    chk(s == -run_sum[j], gap_seen[j] ? "R6" : "R5", s, -run_sum[j]);
                    run_sum[j] = 0;
                end
                gap_seen[j] = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        level_code = 4'd0;
        #1ns;
        chk(cell_drive == 8'h00, "R8", int'(cell_drive), 0);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        for (int j = 0; j < 7; j++) begin
            open_pos[j] = 0;
            open_neg[j] = 0;
        end
        clear_model();
        #1ns;
        chk(cell_drive == 8'h00, "R8", int'(cell_drive), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++) apply(c);
        for (int r = 0; r < 50; r++) begin
            apply(1); apply(3); apply(7); apply(5);
        end
        for (int r = 0; r < 40; r++) begin
            apply(1); apply(2); apply(3); apply(0);
            apply(5); apply(8); apply(7); apply(4);
        end
        for (int r = 0; r < 3000; r++) apply($urandom_range(0, 15));
        apply(1); apply(3);
        do_reset();
        for (int r = 0; r < 1000; r++) apply($urandom_range(0, 15));
        // R7: both pair types seen at every node
        for (int j = 0; j < 7; j++) begin
            chk(open_pos[j] > 0, "R7", open_pos[j], 1);
            chk(open_neg[j] > 0, "R7", open_neg[j], 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            vec_cnt++;
            bad_cnt++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end
endmodule